// File: doc/BRIEF.md
# Periodic Timer Interrupt Sequencer

This block produces a periodic timer interrupt for a pipelined core and steers the core into the interrupt handler. Software gives a period in microseconds. The block turns it into a count of clock cycles at 25 cycles per microsecond and arms a deadline against a free-running 64-bit cycle counter. When the deadline is reached and the status word's interrupt-disable bit is clear, the block first stops new instructions from dispatching. It then waits until the instruction window is empty and no multi-op microcode sequence is running.

In the entry cycle the block asserts a single-cycle group of outputs. These flush the fetch queue, redirect fetch to the interrupt vector, supply the return address for the interrupt-mode link register, save the current status word into the interrupt-mode saved-status register, and load a new status word with the interrupt-mode byte. The block then waits in its handler state until the core signals a committed (non-speculative) exception return.

The state machine has three states. NORMAL is the reset state and is where deadlines are watched. FLUSH_WAIT stalls dispatch until the pipeline is quiet. IN_HANDLER lasts from entry until the exception return. The named transitions are:
- *fire*: NORMAL to FLUSH_WAIT, when the deadline is due and the interrupt-disable bit is clear.
- *enter*: FLUSH_WAIT to IN_HANDLER, when the window is empty and no microcode is running.
- *resume*: IN_HANDLER to NORMAL, on an exception return.

Top module: `tick_irq_sequencer`

## Requirements
- R1: After reset the state is NORMAL, the cycle counter is 0, the timer is disarmed, `dispatch_ok` is 1, and none of `fetch_flush`, `save_status_we` and `load_status_we` is asserted.
- R2: The cycle counter increments on every clock. A `cfg_we` strobe sampled when the counter holds N sets the period to 25 × `cfg_usec` cycles and the deadline to N plus that period.
- R3: In NORMAL, a nonzero deadline that the counter has reached or passed (unsigned 64-bit compare) takes the *fire* transition to FLUSH_WAIT on that clock, provided status bit 7 is 0. The same clock advances the deadline by one period, so `dispatch_ok` falls in the cycle after the counter equals the deadline.
- R4: In FLUSH_WAIT, `dispatch_ok` is 0 unless `ucode_busy` is 1.
- R5: The *enter* transition happens only in FLUSH_WAIT, and only in a cycle with `win_empty` at 1 and `ucode_busy` at 0.
- R6: In the entry cycle the block asserts `fetch_flush`, `save_status_we` and `load_status_we`, drives `redirect_pc` to 0x18 and `irq_link` to the resume PC plus 4, drives `save_status` to `status_i`, and drives `load_status` to `status_i` with its low byte replaced by 0xD2.
- R7: The resume PC is `fetch_q_pc` when `fetch_q_valid` is 1, and `pred_pc` otherwise.
- R8: Entry lasts exactly one cycle and is followed by IN_HANDLER. In IN_HANDLER `dispatch_ok` is 1 and deadlines do not cause a new interrupt.
- R9: `exc_return` takes the *resume* transition from IN_HANDLER to NORMAL. It has no effect in NORMAL or FLUSH_WAIT.
- R10: While status bit 7 is 1, a reached deadline neither fires nor advances. The interrupt is taken on the clock after the bit clears.
- R11: Programming a period of 0 disarms the timer, so no interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Period programming strobe |
| cfg_usec | input | 16 | Period in microseconds |
| status_i | input | 32 | Current status word; bit 7 is interrupt disable |
| win_empty | input | 1 | Instruction window holds no operations |
| ucode_busy | input | 1 | A multi-op microcode sequence is in progress |
| fetch_q_valid | input | 1 | Fetch queue holds at least one entry |
| fetch_q_pc | input | 32 | PC of the oldest fetch queue entry |
| pred_pc | input | 32 | Predicted fetch PC |
| exc_return | input | 1 | Committed exception return |
| dispatch_ok | output | 1 | Dispatch of new operations is allowed |
| fetch_flush | output | 1 | Empty the fetch queue and redirect fetch |
| redirect_pc | output | 32 | New fetch PC (the interrupt vector) |
| irq_link | output | 32 | Value for the interrupt-mode link register |
| save_status_we | output | 1 | Write enable for the interrupt-mode saved status |
| save_status | output | 32 | Status word to save |
| load_status_we | output | 1 | Write enable for the current status word |
| load_status | output | 32 | New status word |

## Verification
The embedded assertions check on every cycle that:
- the block leaves NORMAL only after a due deadline seen with the interrupt-disable bit clear;
- it returns to NORMAL only on an exception return;
- each entry pulse is a single cycle followed by unblocked dispatch;
- a zero period never produces a due deadline.

Other behaviours need the bench's scenarios, which compare every entry against an expected queue:
- the exact cycle at which the interrupt fires relative to the programmed period and the deadline's advance;
- the choice of resume PC;
- the status byte rewrite;
- the hold-off while the interrupt-disable bit is set;
- that exception returns are ignored outside the handler.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL     = 2'd0,
        ST_FLUSH_WAIT = 2'd1,
        ST_IN_HANDLER = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tick_deadline.sv
module tick_deadline #(
    parameter int CNT_W        = 64,
    parameter int USEC_W       = 16,
    parameter int CYC_PER_USEC = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [USEC_W-1:0] cfg_usec,
    input  logic              advance,
    output logic              due
);
    logic [CNT_W-1:0] cnt_q, period_q, deadline_q, period_new;

    assign period_new = CNT_W'(cfg_usec) * CNT_W'(CYC_PER_USEC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            period_q   <= '0;
            deadline_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cfg_we) begin
                period_q   <= period_new;
                deadline_q <= (period_new == '0) ? '0 : cnt_q + period_new;
            end else if (advance) begin
                deadline_q <= deadline_q + period_q;
            end
        end
    end

    // unsigned compare; a zero deadline means disarmed
    assign due = (deadline_q != '0) && (cnt_q >= deadline_q);

    assert_zero_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) |-> !due);
endmodule

// File: rtl/tick_resume.sv
module tick_resume #(
    parameter int PC_W = 32
) (
    input  logic            fetch_q_valid,
    input  logic [PC_W-1:0] fetch_q_pc,
    input  logic [PC_W-1:0] pred_pc,
    output logic [PC_W-1:0] link_val
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    always_comb begin
        link_val = (fetch_q_valid ? fetch_q_pc : pred_pc) + STEP;
    end
endmodule

// File: rtl/tick_irq_fsm.sv
module tick_irq_fsm
    import tick_irq_pkg::*;
#(
    parameter int             PC_W      = 32,
    parameter int             ST_W      = 32,
    parameter int             IBIT      = 7,
    parameter logic [31:0]    VECTOR    = 32'h18,
    parameter logic [7:0]     MODE_BYTE = 8'hD2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            due,
    input  logic [ST_W-1:0] status_i,
    input  logic            win_empty,
    input  logic            ucode_busy,
    input  logic            exc_return,
    input  logic [PC_W-1:0] link_in,
    output logic            advance,
    output logic            dispatch_ok,
    output logic            fetch_flush,
    output logic [PC_W-1:0] redirect_pc,
    output logic [PC_W-1:0] irq_link,
    output logic            save_status_we,
    output logic [ST_W-1:0] save_status,
    output logic            load_status_we,
    output logic [ST_W-1:0] load_status
);
    seq_state_t state_q, state_d;
    logic       fire, enter;

    assign fire  = (state_q == ST_NORMAL) && due && !status_i[IBIT];
    assign enter = (state_q == ST_FLUSH_WAIT) && win_empty && !ucode_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:     if (fire)       state_d = ST_FLUSH_WAIT;
            ST_FLUSH_WAIT: if (enter)      state_d = ST_IN_HANDLER;
            ST_IN_HANDLER: if (exc_return) state_d = ST_NORMAL;
            default:                       state_d = ST_NORMAL;
        endcase
    end

    always_comb begin
        advance        = fire;
        dispatch_ok    = 1'b1;
        fetch_flush    = 1'b0;
        redirect_pc    = PC_W'(VECTOR);
        irq_link       = link_in;
        save_status_we = 1'b0;
        save_status    = status_i;
        load_status_we = 1'b0;
        load_status    = {status_i[ST_W-1:8], MODE_BYTE};
        unique case (state_q)
            ST_NORMAL: ;
            ST_FLUSH_WAIT: begin
                dispatch_ok    = ucode_busy;
                fetch_flush    = enter;
                save_status_we = enter;
                load_status_we = enter;
            end
            ST_IN_HANDLER: ;
            default: ;
        endcase
    end

    assert_fire_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH_WAIT && $past(state_q) == ST_NORMAL)
        |-> ($past(due) && !$past(status_i[IBIT])));

    assert_resume_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && $past(state_q) == ST_IN_HANDLER) |-> $past(exc_return));

    assert_entry_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        save_status_we |=> (dispatch_ok && !save_status_we && !fetch_flush));

    assert_entry_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IN_HANDLER && $past(state_q) == ST_FLUSH_WAIT)
        |-> ($past(win_empty) && !$past(ucode_busy)));
endmodule

// File: rtl/tick_irq_sequencer.sv
module tick_irq_sequencer #(
    parameter int CNT_W        = 64,
    parameter int USEC_W       = 16,
    parameter int CYC_PER_USEC = 25,
    parameter int PC_W         = 32,
    parameter int ST_W         = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [USEC_W-1:0] cfg_usec,
    input  logic [ST_W-1:0]   status_i,
    input  logic              win_empty,
    input  logic              ucode_busy,
    input  logic              fetch_q_valid,
    input  logic [PC_W-1:0]   fetch_q_pc,
    input  logic [PC_W-1:0]   pred_pc,
    input  logic              exc_return,
    output logic              dispatch_ok,
    output logic              fetch_flush,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [PC_W-1:0]   irq_link,
    output logic              save_status_we,
    output logic [ST_W-1:0]   save_status,
    output logic              load_status_we,
    output logic [ST_W-1:0]   load_status
);
    logic            due, advance;
    logic [PC_W-1:0] link_val;

    tick_deadline #(.CNT_W(CNT_W), .USEC_W(USEC_W), .CYC_PER_USEC(CYC_PER_USEC)) u_deadline (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_usec(cfg_usec),
        .advance(advance), .due(due)
    );

    tick_resume #(.PC_W(PC_W)) u_resume (
        .fetch_q_valid(fetch_q_valid), .fetch_q_pc(fetch_q_pc),
        .pred_pc(pred_pc), .link_val(link_val)
    );

    tick_irq_fsm #(.PC_W(PC_W), .ST_W(ST_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .due(due), .status_i(status_i),
        .win_empty(win_empty), .ucode_busy(ucode_busy), .exc_return(exc_return),
        .link_in(link_val), .advance(advance), .dispatch_ok(dispatch_ok),
        .fetch_flush(fetch_flush), .redirect_pc(redirect_pc), .irq_link(irq_link),
        .save_status_we(save_status_we), .save_status(save_status),
        .load_status_we(load_status_we), .load_status(load_status)
    );
endmodule

// File: tb/tb_tick_irq_sequencer.sv
module tb_tick_irq_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_usec = '0;
    logic [31:0] status_i = 32'h13;
    logic        win_empty = 1'b0;
    logic        ucode_busy = 1'b0;
    logic        fetch_q_valid = 1'b0;
    logic [31:0] fetch_q_pc = '0;
    logic [31:0] pred_pc = '0;
    logic        exc_return = 1'b0;
    logic        dispatch_ok, fetch_flush, save_status_we, load_status_we;
    logic [31:0] redirect_pc, irq_link, save_status, load_status;

    tick_irq_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_usec(cfg_usec),
        .status_i(status_i), .win_empty(win_empty), .ucode_busy(ucode_busy),
        .fetch_q_valid(fetch_q_valid), .fetch_q_pc(fetch_q_pc), .pred_pc(pred_pc),
        .exc_return(exc_return), .dispatch_ok(dispatch_ok), .fetch_flush(fetch_flush),
        .redirect_pc(redirect_pc), .irq_link(irq_link), .save_status_we(save_status_we),
        .save_status(save_status), .load_status_we(load_status_we), .load_status(load_status)
    );

    always #5 clk = ~clk;

    typedef struct {
        longint      cyc;
        logic [31:0] link;
        logic [31:0] saved;
        logic [31:0] loaded;
    } entry_t;

    entry_t exp_q[$];
    longint tb_cyc = 0;
    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;

    // reference cycle count: 0 at reset, +1 per clock (R2)
    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= 0;
        else        tb_cyc <= tb_cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input longint c);
        while (tb_cyc < c) step();
    endtask

    task automatic push_exp(input longint c, input logic [31:0] lk, input logic [31:0] st);
        entry_t e;
        e.cyc = c; e.link = lk; e.saved = st; e.loaded = {st[31:8], 8'hD2};
        exp_q.push_back(e);
    endtask

    // scoreboard monitor: every entry pulse must match the next expected item
    always @(negedge clk) begin
        if (rst_n && save_status_we && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected entry", tb_cyc, 0);
            end else begin
                entry_t e;
                e = exp_q.pop_front();
                chk(tb_cyc == e.cyc, "R3 entry cycle", tb_cyc, e.cyc);
                chk(irq_link == e.link, "R7 link", irq_link, e.link);
                chk(save_status == e.saved, "R6 saved status", save_status, e.saved);
                chk(load_status == e.loaded, "R6 loaded status", load_status, e.loaded);
                chk(redirect_pc == 32'h18, "R6 vector", redirect_pc, 32'h18);
                chk(fetch_flush && load_status_we, "R6 flush/load", {fetch_flush, load_status_we}, 2'b11);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", tb_cyc, 0);
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        longint d1, d2, d3;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dispatch_ok == 1'b1, "R1 dispatch_ok", dispatch_ok, 1);
        chk({fetch_flush, save_status_we, load_status_we} == 3'b000, "R1 pulses", {fetch_flush, save_status_we, load_status_we}, 0);

        // R2 program 2 us = 50 cycles, window busy
        step();
        d1 = tb_cyc + 50;
        cfg_we = 1'b1; cfg_usec = 16'd2;
        step();
        cfg_we = 1'b0;
        wait_until(d1);
        @(negedge clk);
        chk(dispatch_ok == 1'b1, "R3 not early", dispatch_ok, 1);
        step();
        @(negedge clk);
        chk(dispatch_ok == 1'b0, "R3 fire/R4 block", dispatch_ok, 0);
        // R9 exc_return ignored while waiting
        step(); exc_return = 1'b1;
        step(); exc_return = 1'b0;
        @(negedge clk);
        chk(dispatch_ok == 1'b0, "R9 ignored in flush wait", dispatch_ok, 0);
        // R4 microcode lets dispatch through; R5 no entry while busy
        step(); ucode_busy = 1'b1; win_empty = 1'b1;
        @(negedge clk);
        chk(dispatch_ok == 1'b1, "R4 ucode pass", dispatch_ok, 1);
        chk(save_status_we == 1'b0, "R5 no entry while busy", save_status_we, 0);
        // entry with queued fetch entry (R7)
        step();
        ucode_busy = 1'b0; fetch_q_valid = 1'b1; fetch_q_pc = 32'h1000; status_i = 32'h6000_0013;
        push_exp(tb_cyc, 32'h1004, 32'h6000_0013);
        @(negedge clk);
        chk(dispatch_ok == 1'b0, "R4 blocked at entry", dispatch_ok, 0);
        step();
        @(negedge clk);
        chk(dispatch_ok == 1'b1, "R8 handler dispatch", dispatch_ok, 1);

        // return; next deadline d1+50, resume from predicted PC (R7)
        step(); exc_return = 1'b1;
        step(); exc_return = 1'b0;
        fetch_q_valid = 1'b0; pred_pc = 32'h2000; status_i = 32'h1F;
        d2 = d1 + 50;
        push_exp(d2 + 1, 32'h2004, 32'h1F);
        wait_until(d2 + 3);

        // R8 deadline d2+50 passes while in handler: no interrupt
        d3 = d2 + 50;
        wait_until(d3 + 20);
        @(negedge clk);
        chk(dispatch_ok == 1'b1, "R8 deadline ignored in handler", dispatch_ok, 1);
        // R10 return with I bit set
        step(); exc_return = 1'b1; status_i = 32'h93;
        step(); exc_return = 1'b0;
        wait_until(d3 + 30);
        @(negedge clk);
        chk(dispatch_ok == 1'b1 && save_status_we == 1'b0, "R10 masked", dispatch_ok, 1);
        status_i = 32'h13;
        push_exp(d3 + 31, 32'h2004, 32'h13);
        wait_until(d3 + 33);
        step(); exc_return = 1'b1;
        step(); exc_return = 1'b0;

        // R11 zero period disarms
        cfg_we = 1'b1; cfg_usec = 16'd0;
        step();
        cfg_we = 1'b0;
        repeat (200) step();
        @(negedge clk);
        chk(dispatch_ok == 1'b1, "R11 disarmed", dispatch_ok, 1);
        chk(exp_q.size() == 0, "R6 all entries seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule